// File: doc/BRIEF.md
# Dual-Issue Execution Unit Dispatcher

This block sits in front of the execution units of one processing core. Two in-order instruction queues present one decoded head each: a valid bit and a 3-bit operation class. Every cycle the dispatcher decides which heads can start, accepts them with a same-cycle take strobe, and reports each launch one cycle later as a registered issue strobe together with a unit-select code. At most two operations launch per cycle, one from each queue.

There are five targets: two 16-lane arithmetic SIMD units, one special-function unit, one 16-lane 32-bit load/store unit and one texture unit. They differ in what they accept. Integer multiply runs only on the first SIMD. A double-precision fused multiply-add takes both SIMDs together. Each unit keeps its own busy countdown, loaded when an operation starts on it. A long operation on one unit therefore holds back only the instructions that need that unit.

Queue 0 has precedence when both heads compete for a unit, and the losing head retries in the following cycle. Operation classes: 0 = FP32 FMA or INT32 add, 1 = INT32 multiply, 2 = FP64 FMA, 3 = special function, 4 = interpolation, 5 = load/store, 6 = texture, 7 = reserved. Unit codes: 0 = SIMD0, 1 = SIMD1, 2 = special-function unit, 3 = load/store, 4 = texture, 5 = SIMD0 and SIMD1 together.

Top module: `dsp_dual_issue`

## Requirements
- R1: Synchronous active-high reset clears both issue strobes and returns every unit to idle, so any operation class 0 to 6 presented as the first head after reset is taken in that first cycle.
- R2: No two operations start on the same unit in the same cycle, and no unit starts a new operation before its busy countdown has expired.
- R3: Class 0 goes to SIMD0 (code 0) when SIMD0 is idle and was not claimed by queue 0 in that cycle, otherwise to SIMD1 (code 1), otherwise it waits.
- R4: Class 1 runs only on SIMD0 (code 0); when SIMD0 is unavailable the head waits, even if SIMD1 is idle.
- R5: Class 2 needs both SIMDs idle and unclaimed, reports code 5, and keeps both SIMDs busy for FMA64_CYC cycles (default 2), so the next SIMD operation may start FMA64_CYC cycles after it.
- R6: Class 3 keeps the special-function unit busy for SPECIAL_CYC cycles (default 4). The next class 3 or 4 operation starts exactly SPECIAL_CYC cycles later.
- R7: A busy unit never blocks a head that needs a different idle unit. Operations on other units keep starting in every cycle while the special-function unit is busy.
- R8: Classes 4, 5 and 6 and SIMD classes 0 and 1 occupy their unit for a single cycle, so back-to-back operations of the same class start in consecutive cycles.
- R9: When both heads need the same unit and only one can have it, queue 0 takes it and queue 1 waits.
- R10: A head taken in cycle N produces the issue strobe of its queue in cycle N+1, with the unit code of R3, R4, R5 or the fixed code of its class (special function and interpolation 2, load/store 3, texture 4).
- R11: A class 7 head is never taken and blocks its own queue, while the other queue continues to issue.
- R12: Each queue takes only its head, never out of order. The take output stays low while the head's unit is unavailable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q0_valid | input | 1 | Queue 0 head present |
| q0_opc | input | 3 | Queue 0 head operation class |
| q1_valid | input | 1 | Queue 1 head present |
| q1_opc | input | 3 | Queue 1 head operation class |
| q0_take | output | 1 | Queue 0 head accepted this cycle |
| q1_take | output | 1 | Queue 1 head accepted this cycle |
| iss0_stb | output | 1 | Issue strobe for queue 0's launch of the previous cycle |
| iss0_unit | output | 3 | Unit code of queue 0's launch |
| iss1_stb | output | 1 | Issue strobe for queue 1's launch of the previous cycle |
| iss1_unit | output | 3 | Unit code of queue 1's launch |

## Verification
The bench builds the block with its default parameters: SPECIAL_CYC of 4 and FMA64_CYC of 2, with single-cycle occupancy for everything else. A four-cycle special-function window leaves enough room to show other units issuing in every cycle behind it. The two-cycle FP64 hold creates a cycle in which SIMD work is refused while load/store and texture traffic goes ahead. Directed pairs of heads exercise SIMD selection, multiply restriction, priority and the reserved class. A long mixed stream then meets every combination of busy windows against both queues.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int N_UNITS = 5;
  localparam int N_SLOTS = 2;

  localparam int U_SIMD0 = 0;
  localparam int U_SIMD1 = 1;
  localparam int U_SFU   = 2;
  localparam int U_LDST  = 3;
  localparam int U_TEX   = 4;

  localparam logic [2:0] CODE_PAIR = 3'd5;

  typedef enum logic [2:0] {
    OPC_FMA32   = 3'd0,
    OPC_IMUL    = 3'd1,
    OPC_FMA64   = 3'd2,
    OPC_SPECIAL = 3'd3,
    OPC_INTERP  = 3'd4,
    OPC_LDST    = 3'd5,
    OPC_TEX     = 3'd6,
    OPC_RSVD    = 3'd7
  } opc_e;

  // Units an operation class would occupy, given which units are available.
  // Empty result means the head must wait.
  function automatic logic [N_UNITS-1:0] claim_for(logic [2:0] opc,
                                                   logic [N_UNITS-1:0] avail);
    logic [N_UNITS-1:0] c;
    c = '0;
    case (opc_e'(opc))
      OPC_FMA32: begin
        if (avail[U_SIMD0])      c[U_SIMD0] = 1'b1;
        else if (avail[U_SIMD1]) c[U_SIMD1] = 1'b1;
      end
      OPC_IMUL:    if (avail[U_SIMD0]) c[U_SIMD0] = 1'b1;
      OPC_FMA64: begin
        if (avail[U_SIMD0] && avail[U_SIMD1]) begin
          c[U_SIMD0] = 1'b1;
          c[U_SIMD1] = 1'b1;
        end
      end
      OPC_SPECIAL,
      OPC_INTERP:  if (avail[U_SFU])  c[U_SFU]  = 1'b1;
      OPC_LDST:    if (avail[U_LDST]) c[U_LDST] = 1'b1;
      OPC_TEX:     if (avail[U_TEX])  c[U_TEX]  = 1'b1;
      default:     c = '0;
    endcase
    return c;
  endfunction

  // Unit-select code reported for a claim vector.
  function automatic logic [2:0] code_of(logic [N_UNITS-1:0] claim);
    logic [2:0] code;
    code = 3'd0;
    if (claim[U_SIMD0] && claim[U_SIMD1]) begin
      code = CODE_PAIR;
    end else begin
      for (int u = N_UNITS - 1; u >= 0; u--) begin
        if (claim[u]) code = 3'(u);
      end
    end
    return code;
  endfunction

  // Occupancy in cycles of an operation class on the unit(s) it takes.
  function automatic int hold_of(logic [2:0] opc, int base_cyc,
                                 int special_cyc, int fma64_cyc);
    case (opc_e'(opc))
      OPC_SPECIAL: return special_cyc;
      OPC_FMA64:   return fma64_cyc;
      default:     return base_cyc;
    endcase
  endfunction

endpackage

// File: rtl/dsp_busy_ctr.sv
module dsp_busy_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] hold,
  output logic             idle
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= hold - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign idle = (cnt == '0);

  // R2
  load_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> idle);

  // R7
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !load) |=> idle);

endmodule

// File: rtl/dsp_slot_pick.sv
module dsp_slot_pick
  import dsp_pkg::*;
(
  input  logic               valid,
  input  logic [2:0]         opc,
  input  logic [N_UNITS-1:0] avail,
  output logic [N_UNITS-1:0] claim,
  output logic               take,
  output logic [2:0]         code
);

  always_comb begin
    claim = valid ? claim_for(opc, avail) : '0;
    take  = (claim != '0);
    code  = code_of(claim);
  end

endmodule

// File: rtl/dsp_dual_issue.sv
module dsp_dual_issue
  import dsp_pkg::*;
#(
  parameter int BASE_CYC    = 1,
  parameter int SPECIAL_CYC = 4,
  parameter int FMA64_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       q0_valid,
  input  logic [2:0] q0_opc,
  input  logic       q1_valid,
  input  logic [2:0] q1_opc,
  output logic       q0_take,
  output logic       q1_take,
  output logic       iss0_stb,
  output logic [2:0] iss0_unit,
  output logic       iss1_stb,
  output logic [2:0] iss1_unit
);

  localparam int MAX_CYC = (SPECIAL_CYC > FMA64_CYC)
                         ? ((SPECIAL_CYC > BASE_CYC) ? SPECIAL_CYC : BASE_CYC)
                         : ((FMA64_CYC > BASE_CYC) ? FMA64_CYC : BASE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [N_SLOTS-1:0]              head_vld;
  logic [N_SLOTS-1:0][2:0]         head_opc;
  logic [N_SLOTS:0][N_UNITS-1:0]   avail;
  logic [N_SLOTS-1:0][N_UNITS-1:0] claim;
  logic [N_SLOTS-1:0]              take;
  logic [N_SLOTS-1:0][2:0]         code;
  logic [N_UNITS-1:0]              unit_idle;
  logic [N_UNITS-1:0]              unit_load;
  logic [N_SLOTS-1:0]              stb_q;
  logic [N_SLOTS-1:0][2:0]         unit_q;
  logic                            sfu_long_start;

  assign head_vld = {q1_valid, q0_valid};
  assign head_opc = {q1_opc, q0_opc};
  assign avail[0] = unit_idle;

  // Slot chain: queue 0 picks first, queue 1 sees what remains.
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    dsp_slot_pick u_pick (
      .valid (head_vld[s]),
      .opc   (head_opc[s]),
      .avail (avail[s]),
      .claim (claim[s]),
      .take  (take[s]),
      .code  (code[s])
    );
    assign avail[s+1] = avail[s] & ~claim[s];
  end

  // Per-unit busy countdowns.
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [CNT_W-1:0] hold_u;
    assign unit_load[u] = claim[0][u] | claim[1][u];
    assign hold_u = claim[0][u]
                  ? CNT_W'(hold_of(head_opc[0], BASE_CYC, SPECIAL_CYC, FMA64_CYC))
                  : CNT_W'(hold_of(head_opc[1], BASE_CYC, SPECIAL_CYC, FMA64_CYC));
    dsp_busy_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .load (unit_load[u]),
      .hold (hold_u),
      .idle (unit_idle[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= '0;
      unit_q <= '0;
    end else begin
      stb_q  <= take;
      unit_q <= code;
    end
  end

  assign q0_take   = take[0];
  assign q1_take   = take[1];
  assign iss0_stb  = stb_q[0];
  assign iss0_unit = unit_q[0];
  assign iss1_stb  = stb_q[1];
  assign iss1_unit = unit_q[1];

  assign sfu_long_start = (claim[0][U_SFU] && head_opc[0] == OPC_SPECIAL)
                       || (claim[1][U_SFU] && head_opc[1] == OPC_SPECIAL);

  // R2
  disjoint_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (claim[0] & claim[1]) == '0);

  // R10
  strobe0_follow_chk: assert property (@(posedge clk) disable iff (rst)
    q0_take |=> iss0_stb);

  // R10
  strobe1_follow_chk: assert property (@(posedge clk) disable iff (rst)
    q1_take |=> iss1_stb);

  // R9
  queue0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (q0_take && q1_valid && q1_opc == q0_opc && q0_opc != OPC_FMA32)
      |-> !q1_take);

  // R11
  rsvd_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
    ((q0_valid && q0_opc == OPC_RSVD) |-> !q0_take)
    and ((q1_valid && q1_opc == OPC_RSVD) |-> !q1_take));

  // R4
  imul_simd0_chk: assert property (@(posedge clk) disable iff (rst)
    (q1_take && q1_opc == OPC_IMUL) |=> (iss1_unit == 3'd0));

  // R6
  special_holds_sfu_chk: assert property (@(posedge clk) disable iff (rst)
    (sfu_long_start && SPECIAL_CYC > 1) |=> !unit_idle[U_SFU]);

  // R12
  take_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
    (q0_take |-> q0_valid) and (q1_take |-> q1_valid));

endmodule

// File: tb/dsp_dual_issue_tb_top.sv
module dsp_dual_issue_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       q0_valid = 1'b0, q1_valid = 1'b0;
  logic [2:0] q0_opc = '0, q1_opc = '0;
  logic       q0_take, q1_take;
  logic       iss0_stb, iss1_stb;
  logic [2:0] iss0_unit, iss1_unit;

  dsp_dual_issue dut_i (
    .clk(clk), .rst(rst),
    .q0_valid(q0_valid), .q0_opc(q0_opc),
    .q1_valid(q1_valid), .q1_opc(q1_opc),
    .q0_take(q0_take), .q1_take(q1_take),
    .iss0_stb(iss0_stb), .iss0_unit(iss0_unit),
    .iss1_stb(iss1_stb), .iss1_unit(iss1_unit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int prog0[$];
  int prog1[$];
  int idx0, idx1;
  int cyc = 0;
  int free_at[5];
  int exp0[$];   // expected unit code of next strobe, -1 = none
  int exp1[$];

  function automatic string tag_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R8";
      5, 6: return "R7";
      default: return "R11";
    endcase
  endfunction

  // Bench view of unit choice: returns unit code or -1.
  function automatic int bench_pick(int op, bit [4:0] av);
    if (op == 0) return av[0] ? 0 : (av[1] ? 1 : -1);
    if (op == 1) return av[0] ? 0 : -1;
    if (op == 2) return (av[0] && av[1]) ? 5 : -1;
    if (op == 3 || op == 4) return av[2] ? 2 : -1;
    if (op == 5) return av[3] ? 3 : -1;
    if (op == 6) return av[4] ? 4 : -1;
    return -1;
  endfunction

  function automatic bit [4:0] mask_of(int u);
    return (u == 5) ? 5'b00011 : 5'(1 << u);
  endfunction

  function automatic int occ_of(int op);
    return (op == 2) ? 2 : ((op == 3) ? 4 : 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_strobe(int slot, logic stb, logic [2:0] unit);
    int e;
    if (slot == 0) e = (exp0.size() > 0) ? exp0.pop_front() : -1;
    else           e = (exp1.size() > 0) ? exp1.pop_front() : -1;
    check(stb == (e >= 0), "R10", $sformatf("strobe slot%0d", slot),
          int'(stb), int'(e >= 0));
    if (e >= 0 && stb)
      check(int'(unit) == e, "R10", $sformatf("unit slot%0d", slot),
            int'(unit), e);
  endtask

  // One cycle, entered just after a falling edge.
  task automatic step();
    bit [4:0] av;
    int op0, op1, u0, u1;
    bit v0, v1;
    check_strobe(0, iss0_stb, iss0_unit);
    check_strobe(1, iss1_stb, iss1_unit);
    if (iss0_stb && iss1_stb)
      check(iss0_unit != iss1_unit, "R2", "distinct units",
            int'(iss0_unit), -1);
    for (int u = 0; u < 5; u++) av[u] = (free_at[u] <= cyc);
    v0 = idx0 < prog0.size();
    v1 = idx1 < prog1.size();
    op0 = v0 ? prog0[idx0] : 0;
    op1 = v1 ? prog1[idx1] : 0;
    u0 = v0 ? bench_pick(op0, av) : -1;
    if (u0 >= 0) av = av & ~mask_of(u0);
    u1 = v1 ? bench_pick(op1, av) : -1;
    for (int u = 0; u < 5; u++) begin
      if (u0 >= 0 && mask_of(u0)[u]) free_at[u] = cyc + occ_of(op0);
      if (u1 >= 0 && mask_of(u1)[u]) free_at[u] = cyc + occ_of(op1);
    end
    q0_valid = v0; q0_opc = 3'(op0);
    q1_valid = v1; q1_opc = 3'(op1);
    #1;
    check(q0_take == (u0 >= 0), (u0 >= 0) ? tag_of(op0) : "R12",
          "q0 take", int'(q0_take), int'(u0 >= 0));
    check(q1_take == (u1 >= 0), "R9", "q1 take", int'(q1_take), int'(u1 >= 0));
    exp0.push_back(u0);
    exp1.push_back(u1);
    if (u0 >= 0) idx0++;
    if (u1 >= 0) idx1++;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int limit);
    idx0 = 0; idx1 = 0;
    for (int k = 0; k < limit; k++) begin
      if (idx0 >= prog0.size() && idx1 >= prog1.size()) break;
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 5; u++) free_at[u] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    check(iss0_stb == 1'b0 && iss1_stb == 1'b0, "R1", "strobes after reset",
          int'(iss0_stb | iss1_stb), 0);
    exp0.push_back(-1); exp1.push_back(-1);
    // R1: a long operation accepted in the very first cycle
    prog0 = {3}; prog1 = {2};
    run(4);
    // R3: SIMD selection
    prog0 = {0, 0, 0}; prog1 = {0, 0, 0};
    run(10);
    // R4: multiply only on SIMD0, R9 priority
    prog0 = {1, 1}; prog1 = {1, 1};
    run(10);
    // R5: FP64 holds both SIMDs
    prog0 = {2, 0}; prog1 = {0, 5, 6, 0};
    run(10);
    // R6 and R7: special function window, other units keep issuing
    prog0 = {3, 3, 4}; prog1 = {5, 6, 0, 5, 6, 1, 5};
    run(20);
    // R8: single-cycle classes back to back
    prog0 = {4, 4, 4, 5, 5}; prog1 = {6, 6, 6, 1, 1};
    run(12);
    // R11: reserved class blocks only its own queue
    prog0 = {7}; prog1 = {0, 5, 6, 4};
    run(6);
    // mixed stream
    prog0 = {}; prog1 = {};
    for (int i = 0; i < 150; i++) begin
      prog0.push_back($urandom_range(0, 6));
      prog1.push_back($urandom_range(0, 6));
    end
    run(2000);
    check(idx0 == 150 && idx1 == 150, "R12", "stream drained", idx0 + idx1, 300);
    prog0 = {}; prog1 = {};
    for (int k = 0; k < 3; k++) step();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule